// File: doc/BRIEF.md
# Asynchronous Static Memory Access Sequencer

This block takes one read or write request at a time from an on-chip bus clocked by the system clock. It plays the request out as a sequence of timed phases on an external asynchronous static memory, either an SRAM or a NOR-style device. The length of each phase comes from a configuration field that can be changed at run time. The phases run in this order: address setup, address hold (only when address and data share pins), data setup, then a bus turnaround gap. The block then returns to idle.

The block drives the memory address and the chip select, output enable and write enable strobes, all active low. It also drives an active-low address-valid strobe for the multiplexed bus, together with the data-bus output value and its output-enable. Read data is taken on the last cycle of data setup and returned with a one-cycle done pulse. The bank decodes a fixed 64 Mbyte byte window, so the default address width is 26 bits. The configuration inputs must be held stable from acceptance until the block is ready again.

Top module: `async_sram_seq`

## Requirements
- R1: A request is accepted on a clock edge where `reqValid` and `reqReady` are both high. `reqReady` is high only when the block is idle. It stays low from the cycle after acceptance until the turnaround phase has ended, so a request raised while busy waits.
- R2: Address setup lasts `cfgAddrSetup` cycles (0 to 15), and a value of 0 skips the phase. In multiplexed mode (`cfgMuxed`=1), `memAdvN` is low for exactly these cycles. In non-multiplexed mode, `memAdvN` stays high.
- R3: In multiplexed mode only, an address hold phase follows address setup. It lasts `cfgAddrHold` cycles (1 to 15), and a field value of 0 acts as 1. During address hold, chip select is low and the output enable, write enable and address-valid strobes are high.
- R4: Data setup lasts `cfgDataSetup`+1 cycles (1 to 256). During data setup `memOeN` is low for a read, or `memWeN` is low for a write. Neither strobe is low at any other time, and the two are never low together.
- R5: `memCsN` is low in one unbroken run, from the first cycle of address setup to the last cycle of data setup. While it is low, `memAddr` carries the request address.
- R6: A turnaround of `cfgTurn` cycles (0 to 15) follows data setup. During turnaround `memCsN` is high and `reqReady` is low. A value of 0 returns the block to idle at once.
- R7: `rspValid` pulses high for exactly one cycle per access. The pulse comes in the cycle after the last data-setup cycle. For a read, `rspRdata` holds the value of `memDqIn` sampled on that last data-setup cycle.
- R8: In multiplexed mode, `memDqOe` is high and `memDqOut` equals the low `DW` bits of the address during address setup and address hold. During a write's data setup, `memDqOe` is high and `memDqOut` equals the write data. During a read's data setup, `memDqOe` is low.
- R9: After reset, `memCsN`, `memOeN`, `memWeN` and `memAdvN` are high, `memDqOe` is low, `rspValid` is low and `reqReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle, request can be taken |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | AW | Byte address inside the bank window |
| reqWdata | input | DW | Write data |
| cfgMuxed | input | 1 | 1 = address and data share the DQ pins |
| cfgAddrSetup | input | 4 | Address setup length in cycles |
| cfgAddrHold | input | 4 | Address hold length in cycles (multiplexed only) |
| cfgDataSetup | input | 8 | Data setup length minus one |
| cfgTurn | input | 4 | Turnaround length in cycles |
| rspValid | output | 1 | One-cycle done pulse |
| rspRdata | output | DW | Captured read data |
| memAddr | output | AW | Memory address |
| memCsN | output | 1 | Chip select, active low |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memAdvN | output | 1 | Address valid, active low |
| memDqOut | output | DW | Value driven onto the DQ pins |
| memDqOe | output | 1 | DQ output enable |
| memDqIn | input | DW | Value read from the DQ pins |

## Verification
Suppose the phase state or the down-counter goes wrong. The length of a strobe's low run then differs from its programmed length, and the bench sees this when the access returns to idle, at most a few hundred cycles later. A wrong turnaround state shows as a change in how long `reqReady` stays low while chip select is high. A lost or doubled done pulse shows up in the per-access pulse count. A wrong data-bus select shows in the same cycle, as a mismatch between `memDqOut` and the address or write data. A bad capture shows at the done pulse as wrong read data.

// File: rtl/async_sram_pkg.sv
package async_sram_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_ASET, PH_AHOLD, PH_DSET, PH_TURN
  } phase_t;

  typedef struct packed {
    logic csAct;
    logic oeAct;
    logic weAct;
    logic advAct;
    logic addrOnDq;
    logic wdOnDq;
    logic lastData;
    logic load;
  } strobes_t;
endpackage

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
  import async_sram_pkg::*;
#(
  parameter int SW  = 4,
  parameter int DSW = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           reqValid,
  input  logic           reqWrite,
  output logic           reqReady,
  input  logic           cfgMuxed,
  input  logic [SW-1:0]  cfgAddrSetup,
  input  logic [SW-1:0]  cfgAddrHold,
  input  logic [DSW-1:0] cfgDataSetup,
  input  logic [SW-1:0]  cfgTurn,
  output strobes_t       strb
);
  localparam int CW = (DSW > SW) ? DSW : SW;

  phase_t        phaseQ, phaseD;
  logic [CW-1:0] cntQ, cntD;
  logic          writeQ;
  logic          accept;
  logic [SW-1:0] holdLen;

  assign accept   = reqValid && (phaseQ == PH_IDLE);
  assign reqReady = (phaseQ == PH_IDLE);
  assign holdLen  = (cfgAddrHold == '0) ? SW'(1) : cfgAddrHold;

  always_comb begin
    phaseD = phaseQ;
    cntD   = cntQ;
    case (phaseQ)
      PH_IDLE: if (accept) begin
        if (cfgAddrSetup != '0) begin
          phaseD = PH_ASET;  cntD = CW'(cfgAddrSetup) - CW'(1);
        end else if (cfgMuxed) begin
          phaseD = PH_AHOLD; cntD = CW'(holdLen) - CW'(1);
        end else begin
          phaseD = PH_DSET;  cntD = CW'(cfgDataSetup);
        end
      end
      PH_ASET: if (cntQ != '0) cntD = cntQ - CW'(1);
        else if (cfgMuxed) begin
          phaseD = PH_AHOLD; cntD = CW'(holdLen) - CW'(1);
        end else begin
          phaseD = PH_DSET;  cntD = CW'(cfgDataSetup);
        end
      PH_AHOLD: if (cntQ != '0) cntD = cntQ - CW'(1);
        else begin
          phaseD = PH_DSET;  cntD = CW'(cfgDataSetup);
        end
      PH_DSET: if (cntQ != '0) cntD = cntQ - CW'(1);
        else if (cfgTurn != '0) begin
          phaseD = PH_TURN;  cntD = CW'(cfgTurn) - CW'(1);
        end else phaseD = PH_IDLE;
      PH_TURN: if (cntQ != '0) cntD = cntQ - CW'(1);
        else phaseD = PH_IDLE;
      default: phaseD = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= PH_IDLE;
      cntQ   <= '0;
      writeQ <= 1'b0;
    end else begin
      phaseQ <= phaseD;
      cntQ   <= cntD;
      if (accept) writeQ <= reqWrite;
    end
  end

  always_comb begin
    strb          = '0;
    strb.csAct    = (phaseQ == PH_ASET) || (phaseQ == PH_AHOLD) || (phaseQ == PH_DSET);
    strb.oeAct    = (phaseQ == PH_DSET) && !writeQ;
    strb.weAct    = (phaseQ == PH_DSET) && writeQ;
    strb.advAct   = (phaseQ == PH_ASET) && cfgMuxed;
    strb.addrOnDq = cfgMuxed && ((phaseQ == PH_ASET) || (phaseQ == PH_AHOLD));
    strb.wdOnDq   = (phaseQ == PH_DSET) && writeQ;
    strb.lastData = (phaseQ == PH_DSET) && (cntQ == '0);
    strb.load     = accept;
  end

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady); // R1
  AST_DSET_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ == PH_DSET) |-> (cntQ <= CW'(cfgDataSetup))); // R4
  AST_ADV_ONLY_MUXED: assert property (@(posedge clk) disable iff (!rstN)
    strb.advAct |-> cfgMuxed); // R2
endmodule

// File: rtl/async_sram_dp.sv
module async_sram_dp
  import async_sram_pkg::*;
#(
  parameter int AW = 26,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobes_t      strb,
  input  logic [AW-1:0] reqAddr,
  input  logic [DW-1:0] reqWdata,
  input  logic [DW-1:0] memDqIn,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memDqOut,
  output logic          memDqOe,
  output logic          rspValid,
  output logic [DW-1:0] rspRdata
);
  logic [AW-1:0] addrQ;
  logic [DW-1:0] wdataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      wdataQ   <= '0;
      rspRdata <= '0;
      rspValid <= 1'b0;
    end else begin
      if (strb.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (strb.lastData && strb.oeAct) rspRdata <= memDqIn;
      rspValid <= strb.lastData;
    end
  end

  assign memAddr  = addrQ;
  assign memDqOut = strb.addrOnDq ? addrQ[DW-1:0] : wdataQ;
  assign memDqOe  = strb.addrOnDq || strb.wdOnDq;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid); // R7
  AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    strb.oeAct |-> !memDqOe); // R8
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.oeAct && strb.weAct)); // R4
endmodule

// File: rtl/async_sram_seq.sv
module async_sram_seq
  import async_sram_pkg::*;
#(
  parameter int AW  = 26,
  parameter int DW  = 16,
  parameter int SW  = 4,
  parameter int DSW = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           reqValid,
  output logic           reqReady,
  input  logic           reqWrite,
  input  logic [AW-1:0]  reqAddr,
  input  logic [DW-1:0]  reqWdata,
  input  logic           cfgMuxed,
  input  logic [SW-1:0]  cfgAddrSetup,
  input  logic [SW-1:0]  cfgAddrHold,
  input  logic [DSW-1:0] cfgDataSetup,
  input  logic [SW-1:0]  cfgTurn,
  output logic           rspValid,
  output logic [DW-1:0]  rspRdata,
  output logic [AW-1:0]  memAddr,
  output logic           memCsN,
  output logic           memOeN,
  output logic           memWeN,
  output logic           memAdvN,
  output logic [DW-1:0]  memDqOut,
  output logic           memDqOe,
  input  logic [DW-1:0]  memDqIn
);
  strobes_t strb;

  async_sram_ctrl #(.SW(SW), .DSW(DSW)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .cfgMuxed(cfgMuxed), .cfgAddrSetup(cfgAddrSetup),
    .cfgAddrHold(cfgAddrHold), .cfgDataSetup(cfgDataSetup), .cfgTurn(cfgTurn),
    .strb(strb)
  );

  async_sram_dp #(.AW(AW), .DW(DW)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .memDqIn(memDqIn), .memAddr(memAddr),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .rspValid(rspValid),
    .rspRdata(rspRdata)
  );

  assign memCsN  = !strb.csAct;
  assign memOeN  = !strb.oeAct;
  assign memWeN  = !strb.weAct;
  assign memAdvN = !strb.advAct;
endmodule

// File: tb/sim_async_sram_seq.sv
module sim_async_sram_seq;
  localparam int AW = 26;
  localparam int DW = 16;

  logic clk = 0, rstN = 0;
  logic reqValid = 0, reqWrite = 0, cfgMuxed = 0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic [3:0] cfgAddrSetup = 0, cfgAddrHold = 0, cfgTurn = 0;
  logic [7:0] cfgDataSetup = 0;
  logic reqReady, rspValid, memCsN, memOeN, memWeN, memAdvN, memDqOe;
  logic [DW-1:0] rspRdata, memDqOut, memDqIn;
  logic [AW-1:0] memAddr;

  always #10 clk = ~clk;

  async_sram_seq u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .cfgMuxed(cfgMuxed), .cfgAddrSetup(cfgAddrSetup), .cfgAddrHold(cfgAddrHold),
    .cfgDataSetup(cfgDataSetup), .cfgTurn(cfgTurn), .rspValid(rspValid),
    .rspRdata(rspRdata), .memAddr(memAddr), .memCsN(memCsN), .memOeN(memOeN),
    .memWeN(memWeN), .memAdvN(memAdvN), .memDqOut(memDqOut), .memDqOe(memDqOe),
    .memDqIn(memDqIn)
  );

  logic [DW-1:0] devMem [16];
  logic [DW-1:0] modelMem [16];
  assign memDqIn = devMem[memAddr[3:0]];

  typedef struct {
    logic wr; logic [AW-1:0] addr; logic [DW-1:0] wd; logic [DW-1:0] rd;
    logic mux; int s; int h; int d; int t;
  } item_t;
  item_t q[$];

  int total = 0, bad = 0;
  bit started = 0;

  task automatic check(bit ok, string tag, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver
  task automatic go(bit wr, logic [AW-1:0] a, logic [DW-1:0] wd, bit mux,
                    int s, int h, int d, int t);
    item_t it;
    @(negedge clk);
    cfgMuxed = mux; cfgAddrSetup = 4'(s); cfgAddrHold = 4'(h);
    cfgDataSetup = 8'(d); cfgTurn = 4'(t);
    reqWrite = wr; reqAddr = a; reqWdata = wd; reqValid = 1;
    while (!reqReady) @(negedge clk);
    it.wr = wr; it.addr = a; it.wd = wd; it.mux = mux;
    it.s = s; it.h = (h == 0) ? 1 : h; it.d = d; it.t = t;
    it.rd = modelMem[a[3:0]];
    if (wr) modelMem[a[3:0]] = wd;
    q.push_back(it);
    @(posedge clk);
  endtask

  task automatic drain();
    @(negedge clk);
    reqValid = 0;
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor
  int csCnt, advCnt, holdCnt, oeCnt, weCnt, turnCnt, rspCnt;
  bit busy = 0;
  always @(negedge clk) begin
    if (started) begin
      item_t cur;
      if (q.size() != 0) cur = q[0];
      if (!memWeN) devMem[memAddr[3:0]] = memDqOut;
      if (!memCsN) begin
        busy = 1; csCnt++;
        check(memAddr == cur.addr, "R5 address during access", memAddr, cur.addr);
      end
      if (!memAdvN) begin
        advCnt++;
        check(memDqOe && memDqOut == cur.addr[DW-1:0], "R8 address on DQ in setup", memDqOut, cur.addr[DW-1:0]);
      end
      if (!memCsN && memAdvN && memOeN && memWeN && cur.mux && (advCnt >= cur.s)) begin
        holdCnt++;
        check(memDqOe && memDqOut == cur.addr[DW-1:0], "R8 address on DQ in hold", memDqOut, cur.addr[DW-1:0]);
      end
      if (!memWeN) begin
        weCnt++;
        check(memDqOe && memDqOut == cur.wd, "R8 write data on DQ", memDqOut, cur.wd);
      end
      if (!memOeN) begin
        oeCnt++;
        check(!memDqOe, "R8 DQ released on read", memDqOe, 0);
      end
      if (memCsN && !reqReady && busy) turnCnt++;
      if (rspValid) begin
        rspCnt++;
        if (!cur.wr) check(rspRdata == cur.rd, "R7 read data", rspRdata, cur.rd);
      end
      if (reqReady && busy) begin
        check(advCnt == (cur.mux ? cur.s : 0), "R2 address setup length", advCnt, cur.mux ? cur.s : 0);
        check(holdCnt == (cur.mux ? cur.h : 0), "R3 address hold length", holdCnt, cur.mux ? cur.h : 0);
        check(csCnt == cur.s + (cur.mux ? cur.h : 0) + cur.d + 1, "R5 chip select run",
              csCnt, cur.s + (cur.mux ? cur.h : 0) + cur.d + 1);
        check(oeCnt == (cur.wr ? 0 : cur.d + 1), "R4 output enable length", oeCnt, cur.wr ? 0 : cur.d + 1);
        check(weCnt == (cur.wr ? cur.d + 1 : 0), "R4 write enable length", weCnt, cur.wr ? cur.d + 1 : 0);
        check(turnCnt == cur.t, "R6 turnaround length and R1 ready held low", turnCnt, cur.t);
        check(rspCnt == 1, "R7 one done pulse", rspCnt, 1);
        void'(q.pop_front());
        busy = 0; csCnt = 0; advCnt = 0; holdCnt = 0; oeCnt = 0; weCnt = 0; turnCnt = 0; rspCnt = 0;
      end
    end
  end

  bit finished = 0;
  initial begin
    for (int i = 0; i < 16; i++) begin
      devMem[i] = 16'hA000 + 16'(i);
      modelMem[i] = 16'hA000 + 16'(i);
    end
    csCnt = 0; advCnt = 0; holdCnt = 0; oeCnt = 0; weCnt = 0; turnCnt = 0; rspCnt = 0;
    repeat (3) @(negedge clk);
    check(memCsN && memOeN && memWeN && memAdvN && !memDqOe && !rspValid && reqReady,
          "R9 reset state", {memCsN, memOeN, memWeN, memAdvN, memDqOe, rspValid, reqReady}, 7'b1111001);
    rstN = 1;
    started = 1;
    // non-multiplexed, minimal phases
    go(0, 26'h0000003, 0, 0, 0, 0, 0, 0); drain();
    go(1, 26'h0000005, 16'h1234, 0, 3, 0, 5, 2); drain();
    go(0, 26'h0000005, 0, 0, 3, 0, 5, 2); drain();
    // multiplexed
    go(1, 26'h12AB0C7, 16'hBEEF, 1, 2, 1, 3, 1); drain();
    go(0, 26'h12AB0C7, 0, 1, 0, 0, 0, 0); drain();
    go(0, 26'h3FFFFF9, 0, 1, 15, 15, 2, 15); drain();
    // longest data setup
    go(0, 26'h0000002, 0, 0, 1, 0, 255, 3); drain();
    // back-to-back requests held off while busy
    go(1, 26'h000000A, 16'h5A5A, 1, 1, 2, 1, 4);
    go(0, 26'h000000A, 0, 1, 1, 2, 1, 4);
    go(1, 26'h000000B, 16'hC3C3, 1, 1, 2, 1, 4);
    drain();
    go(0, 26'h000000B, 0, 0, 0, 0, 4, 0);
    go(0, 26'h0000003, 0, 0, 0, 0, 4, 0);
    drain();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule